// File: doc/BRIEF.md
# Compare-Match Event Timer Channel

This block is a 16-bit timer channel that produces events after a programmed number of ticks. A single-cycle `tick_i` pulse stands for one period of the selected count clock, usually a 32768 Hz slow clock. The channel counts these ticks, compares the count against a programmed compare value, and on a match sets a pending flag. It can also raise an interrupt. Depending on the mode, the counter then returns to zero and keeps going (periodic), or returns to zero and halts until software fires it again (one-shot). A free-running mode wraps at the top of the range and flags an overflow instead.

Software controls the channel through a write port. The port has a mode register, a compare register and a command register whose bits separately enable the count clock, disable it, and trigger a restart. Two write-one registers set and clear interrupt mask bits. A read strobe returns the pending flags and clears them. For a periodic tick of `HZ` per second at 32768 Hz, software loads the compare value with `(32768 + HZ/2) / HZ`. For a one-shot delay it loads a delta between 1 and 0xFFFF ticks, which is about two seconds at most.

Top module: `evt_timer_chan`

## Requirements
- R1: While the clock is enabled and not halted, each `tick_i` pulse raises `cnt_o` by one, seen on the cycle after the tick. Without a tick the count holds.
- R2: When MODE bit 1 (auto-restart) is set, the tick that would take the count to the compare value instead sets it to 0 and sets status bit 0 (compare). The event period is therefore exactly the compare value in ticks, so a value of 1 gives an event on every tick and a value of 0 means 65536 ticks.
- R3: When MODE bit 1 is clear (free-run), the count passes the compare value without restarting. It sets status bit 0 when it reaches that value, and wraps from 0xFFFF to 0 setting status bit 1 (overflow).
- R4: When MODE bit 0 (stop-on-compare) is set, a compare event halts the counter, which then ignores ticks. Writing the enable command does not restart it; only a trigger command does.
- R5: The command register (address 2) has bit 0 = enable, bit 1 = disable and bit 2 = trigger. A trigger sets the count to 0 and clears the halt. A trigger takes priority over a tick in the same cycle, so the count reads 0 afterwards.
- R6: A command with both enable and disable set leaves the clock disabled, so later ticks are not counted.
- R7: Writing to address 3 sets the mask bits written as 1, and writing to address 4 clears them. Writing 0xFF to address 4 masks every source. Mask bit n enables status bit n.
- R8: `irq_o` is high exactly when some pending status bit has its mask bit set.
- R9: `stat_o` shows the pending flags. A cycle with `rd_stat_i` high clears them on the following cycle, except that a flag raised in the same cycle as the read stays set.
- R10: After reset the count is 0, no flag is pending, all sources are masked, the clock is disabled, MODE is 0 (free-run, no stop) and the compare value is 0.
- R11: The mode register is at address 0 and the compare register at address 1. A new value takes effect from the cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | One pulse per period of the selected count clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address: 0 mode, 1 compare, 2 command, 3 mask set, 4 mask clear |
| wr_data_i | input | 16 | Register write data |
| rd_stat_i | input | 1 | Status read strobe; clears pending flags |
| stat_o | output | 2 | Pending flags: bit 0 compare, bit 1 overflow |
| cnt_o | output | 16 | Current count value |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench goes after the boundary of the match. A design that compares the current count instead of the next one would make each period one tick too long. That error shows up at once with a compare value of 1, where an event must fire on every tick. One-shot mode is checked for staying stopped after an enable-only command; a design that let enable clear the halt would start counting again. The bench also checks that a trigger coinciding with a tick leaves zero, and that enable with disable in the same command stays disabled. It checks that an event arriving on the same cycle as a status read survives, since a read-clear-wins design would silently drop it. A full 65536-tick free-run wrap checks that the overflow flag is separate from the compare flag.

// File: rtl/evt_timer_pkg.sv
package evt_timer_pkg;

  localparam int CNT_W  = 16;
  localparam int NFLAG  = 2;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_MODE = 3'd0;
  localparam logic [ADDR_W-1:0] A_CMP  = 3'd1;
  localparam logic [ADDR_W-1:0] A_CMD  = 3'd2;
  localparam logic [ADDR_W-1:0] A_MSET = 3'd3;
  localparam logic [ADDR_W-1:0] A_MCLR = 3'd4;

  localparam int F_CMP = 0;
  localparam int F_OVF = 1;

  // Next count value, wrapping at the top of the range.
  function automatic logic [CNT_W-1:0] cnt_next(input logic [CNT_W-1:0] c);
    return c + CNT_W'(1);
  endfunction

  // The step lands on the compare value (0 stands for a full range).
  function automatic logic lands_on(input logic [CNT_W-1:0] nxt,
                                    input logic [CNT_W-1:0] cmpv);
    return nxt == cmpv;
  endfunction

  // Interrupt request from pending flags and enable mask.
  function automatic logic fold_irq(input logic [NFLAG-1:0] f,
                                    input logic [NFLAG-1:0] m);
    return |(f & m);
  endfunction

endpackage

// File: rtl/evt_timer_regs.sv
module evt_timer_regs
  import evt_timer_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int NF = NFLAG,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  output logic          mode_auto_o,
  output logic          mode_stop_o,
  output logic [W-1:0]  cmp_o,
  output logic [NF-1:0] mask_o,
  output logic          cmd_en_o,
  output logic          cmd_dis_o,
  output logic          cmd_trig_o
);

  logic          sel_mode, sel_cmp, sel_cmd, sel_mset, sel_mclr;
  logic [1:0]    mode_q;
  logic [W-1:0]  cmp_q;
  logic [NF-1:0] mask_q;
  logic          unused_hi;

  assign sel_mode = wr_en_i && (wr_addr_i == A_MODE);
  assign sel_cmp  = wr_en_i && (wr_addr_i == A_CMP);
  assign sel_cmd  = wr_en_i && (wr_addr_i == A_CMD);
  assign sel_mset = wr_en_i && (wr_addr_i == A_MSET);
  assign sel_mclr = wr_en_i && (wr_addr_i == A_MCLR);

  assign cmd_en_o   = sel_cmd && wr_data_i[0];
  assign cmd_dis_o  = sel_cmd && wr_data_i[1];
  assign cmd_trig_o = sel_cmd && wr_data_i[2];

  assign unused_hi = ^wr_data_i[W-1:3];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= '0;
      cmp_q  <= '0;
      mask_q <= '0;
    end else begin
      if (sel_mode) mode_q <= wr_data_i[1:0];
      if (sel_cmp)  cmp_q  <= wr_data_i;
      if (sel_mset) mask_q <= mask_q | wr_data_i[NF-1:0];
      else if (sel_mclr) mask_q <= mask_q & ~wr_data_i[NF-1:0];
    end
  end

  assign mode_stop_o = mode_q[0];
  assign mode_auto_o = mode_q[1];
  assign cmp_o       = cmp_q;
  assign mask_o      = mask_q;

  // R7: an all-ones clear write masks every source
  assert_mask_off_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_mclr && (&wr_data_i[NF-1:0])) |=> (mask_o == '0));

  // R11: compare write is visible the next cycle
  assert_cmp_load_R11: assert property (@(posedge clk) disable iff (!rst_n)
    sel_cmp |=> (cmp_o == $past(wr_data_i)));

endmodule

// File: rtl/evt_timer_core.sv
module evt_timer_core
  import evt_timer_pkg::*;
#(
  parameter int W = CNT_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         tick_i,
  input  logic         mode_auto_i,
  input  logic         mode_stop_i,
  input  logic [W-1:0] cmp_i,
  input  logic         cmd_en_i,
  input  logic         cmd_dis_i,
  input  logic         cmd_trig_i,
  output logic [W-1:0] cnt_o,
  output logic         cmp_evt_o,
  output logic         ovf_evt_o,
  output logic         run_o
);

  localparam logic [W-1:0] TOP = {W{1'b1}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] nxt;
  logic         en_q, halt_q;
  logic         step, hit, restart;

  assign nxt     = cnt_next(cnt_q);
  assign hit     = lands_on(nxt, cmp_i);
  assign step    = tick_i && en_q && !halt_q && !cmd_trig_i;
  assign restart = step && hit && mode_auto_i;

  assign cmp_evt_o = step && hit;
  assign ovf_evt_o = step && !mode_auto_i && (cnt_q == TOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else if (cmd_trig_i) begin
      cnt_q  <= '0;
      halt_q <= 1'b0;
    end else if (step) begin
      cnt_q <= restart ? '0 : nxt;
      if (hit && mode_stop_i) halt_q <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)         en_q <= 1'b0;
    else if (cmd_dis_i) en_q <= 1'b0;
    else if (cmd_en_i)  en_q <= 1'b1;
  end

  assign cnt_o = cnt_q;
  assign run_o = en_q && !halt_q;

  // R1: a plain step advances by one
  assert_step_one_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !restart) |=> (cnt_q == W'($past(cnt_q) + W'(1))));

  // R1: no tick, no command -> count holds
  assert_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !cmd_trig_i) |=> $stable(cnt_q));

  // R2: auto-restart match returns to zero
  assert_auto_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt_o && mode_auto_i) |=> (cnt_q == '0));

  // R4: stop-on-compare halts the channel
  assert_halt_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_evt_o && mode_stop_i) |=> !run_o);

  // R5: trigger zeroes the count
  assert_trig_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_trig_i |=> (cnt_q == '0));

  // R6: disable wins over enable
  assert_dis_wins_R6: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_dis_i |=> !run_o);

endmodule

// File: rtl/evt_timer_irq.sv
module evt_timer_irq
  import evt_timer_pkg::*;
#(
  parameter int NF = NFLAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmp_evt_i,
  input  logic          ovf_evt_i,
  input  logic          rd_stat_i,
  input  logic [NF-1:0] mask_i,
  output logic [NF-1:0] stat_o,
  output logic          irq_o
);

  logic [NF-1:0] flag_q;
  logic [NF-1:0] raise;

  always_comb begin
    raise        = '0;
    raise[F_CMP] = cmp_evt_i;
    raise[F_OVF] = ovf_evt_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (rd_stat_i ? '0 : flag_q) | raise;
  end

  assign stat_o = flag_q;
  assign irq_o  = fold_irq(flag_q, mask_i);

  // R8: fully masked -> no request
  assert_irq_masked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_i == '0) |-> !irq_o);

  // R9: read with no new event empties the flags
  assert_rd_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat_i && (raise == '0)) |=> (stat_o == '0));

  // R9: an event on the read cycle survives
  assert_evt_kept_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt_i |=> stat_o[F_CMP]);

endmodule

// File: rtl/evt_timer_chan.sv
module evt_timer_chan
  import evt_timer_pkg::*;
#(
  parameter int W  = CNT_W,
  parameter int NF = NFLAG,
  parameter int AW = ADDR_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          tick_i,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [W-1:0]  wr_data_i,
  input  logic          rd_stat_i,
  output logic [NF-1:0] stat_o,
  output logic [W-1:0]  cnt_o,
  output logic          irq_o
);

  logic          mode_auto, mode_stop;
  logic [W-1:0]  cmp_val;
  logic [NF-1:0] mask;
  logic          cmd_en, cmd_dis, cmd_trig;
  logic          cmp_evt, ovf_evt, run;

  evt_timer_regs #(.W(W), .NF(NF), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .mode_auto_o(mode_auto), .mode_stop_o(mode_stop),
    .cmp_o(cmp_val), .mask_o(mask),
    .cmd_en_o(cmd_en), .cmd_dis_o(cmd_dis), .cmd_trig_o(cmd_trig)
  );

  evt_timer_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .mode_auto_i(mode_auto), .mode_stop_i(mode_stop), .cmp_i(cmp_val),
    .cmd_en_i(cmd_en), .cmd_dis_i(cmd_dis), .cmd_trig_i(cmd_trig),
    .cnt_o(cnt_o), .cmp_evt_o(cmp_evt), .ovf_evt_o(ovf_evt), .run_o(run)
  );

  evt_timer_irq #(.NF(NF)) u_irq (
    .clk(clk), .rst_n(rst_n),
    .cmp_evt_i(cmp_evt), .ovf_evt_i(ovf_evt), .rd_stat_i(rd_stat_i),
    .mask_i(mask), .stat_o(stat_o), .irq_o(irq_o)
  );

  // R10: quiet right after reset
  assert_reset_quiet_R10: assert property (@(posedge clk)
    $rose(rst_n) |-> (cnt_o == '0 && stat_o == '0 && !irq_o && !run));

  // R3: overflow only in free-run mode
  assert_ovf_freerun_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> !mode_auto);

endmodule

// File: tb/sim_evt_timer_chan.sv
`timescale 1ns/1ps
module sim_evt_timer_chan;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        rd_stat_i = 1'b0;
  logic [1:0]  stat_o;
  logic [15:0] cnt_o;
  logic        irq_o;

  always #2.5 clk = ~clk;

  evt_timer_chan u0 (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i), .rd_stat_i(rd_stat_i),
    .stat_o(stat_o), .cnt_o(cnt_o), .irq_o(irq_o)
  );

  int errs = 0;
  int checks = 0;

  // Behavioural reference model
  int m_cnt, m_en, m_halt, m_flags, m_mask, m_auto, m_stop, m_cmp;
  int t_nxt, t_step, t_hit, t_evc, t_evo;
  bit t_en, t_dis, t_trig;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = 0; m_en = 0; m_halt = 0; m_flags = 0;
      m_mask = 0; m_auto = 0; m_stop = 0; m_cmp = 0;
    end else begin
      t_en   = wr_en_i && wr_addr_i == 2 && wr_data_i[0];
      t_dis  = wr_en_i && wr_addr_i == 2 && wr_data_i[1];
      t_trig = wr_en_i && wr_addr_i == 2 && wr_data_i[2];
      t_step = (tick_i && m_en != 0 && m_halt == 0 && !t_trig) ? 1 : 0;
      t_nxt  = (m_cnt + 1) % 65536;
      t_hit  = (t_nxt == m_cmp) ? 1 : 0;
      t_evc  = t_step & t_hit;
      t_evo  = (t_step != 0 && m_auto == 0 && m_cnt == 65535) ? 1 : 0;
      if (t_trig) begin m_cnt = 0; m_halt = 0; end
      else if (t_step != 0) begin
        m_cnt = (t_hit != 0 && m_auto != 0) ? 0 : t_nxt;
        if (t_hit != 0 && m_stop != 0) m_halt = 1;
      end
      if (t_dis) m_en = 0; else if (t_en) m_en = 1;
      if (wr_en_i && wr_addr_i == 0) begin m_stop = wr_data_i[0]; m_auto = wr_data_i[1]; end
      if (wr_en_i && wr_addr_i == 1) m_cmp = wr_data_i;
      if (wr_en_i && wr_addr_i == 3) m_mask = m_mask | (wr_data_i & 3);
      if (wr_en_i && wr_addr_i == 4) m_mask = m_mask & ~(wr_data_i & 3) & 3;
      m_flags = (rd_stat_i ? 0 : m_flags) | t_evc | (t_evo * 2);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cyc(input bit t, input bit w, input int a, input int d, input bit r);
    int m_irq;
    tick_i = t; wr_en_i = w; wr_addr_i = 3'(a); wr_data_i = 16'(d); rd_stat_i = r;
    @(negedge clk);
    m_irq = ((m_flags & m_mask) != 0) ? 1 : 0;
    chk(cnt_o == 16'(m_cnt), "R1 model count", cnt_o, m_cnt);
    chk(stat_o == 2'(m_flags), "R9 model status", stat_o, m_flags);
    chk(irq_o == m_irq[0], "R8 model irq", irq_o, m_irq);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) cyc(1, 0, 0, 0, 0);
    tick_i = 0;
  endtask
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0);
  endtask
  task automatic wr(input int a, input int d);
    cyc(0, 1, a, d, 0);
  endtask
  task automatic rd();
    cyc(0, 0, 0, 0, 1);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", errs, checks);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(1);
    chk(cnt_o == 0 && stat_o == 0 && irq_o == 0, "R10 reset state", cnt_o, 0);
    ticks(2);
    chk(cnt_o == 0, "R10 disabled after reset", cnt_o, 0);

    wr(2, 1);
    ticks(3);
    chk(cnt_o == 3, "R1 three ticks", cnt_o, 3);
    idle(2);
    chk(cnt_o == 3, "R1 holds without tick", cnt_o, 3);

    wr(1, 5); wr(0, 2); wr(2, 4);
    chk(cnt_o == 0, "R5 trigger zero", cnt_o, 0);
    ticks(4);
    chk(cnt_o == 4 && stat_o == 0, "R2 before match", cnt_o, 4);
    ticks(1);
    chk(cnt_o == 0, "R2 restart at compare", cnt_o, 0);
    chk(stat_o[0] == 1, "R2 compare flag", stat_o, 1);
    rd();
    chk(stat_o == 0, "R9 read clears", stat_o, 0);
    ticks(4);
    cyc(1, 0, 0, 0, 1);
    chk(stat_o[0] == 1, "R9 event on read cycle kept", stat_o, 1);

    wr(3, 1);
    chk(irq_o == 1, "R8 irq with mask", irq_o, 1);
    wr(4, 16'hFF);
    chk(irq_o == 0 && stat_o[0] == 1, "R7 mask clear all", irq_o, 0);
    rd();

    wr(0, 3); wr(1, 3); wr(2, 4);
    ticks(3);
    chk(cnt_o == 0 && stat_o[0] == 1, "R4 one-shot fires", cnt_o, 0);
    ticks(4);
    chk(cnt_o == 0, "R4 halted ignores ticks", cnt_o, 0);
    wr(2, 1); ticks(2);
    chk(cnt_o == 0, "R4 enable does not rearm", cnt_o, 0);
    wr(2, 4); ticks(1);
    chk(cnt_o == 1, "R4 trigger rearms", cnt_o, 1);

    wr(2, 3); ticks(2);
    chk(cnt_o == 1, "R6 disable wins", cnt_o, 1);
    wr(2, 1); ticks(1);
    chk(cnt_o == 2, "R6 enable alone", cnt_o, 2);

    cyc(1, 1, 2, 4, 0);
    chk(cnt_o == 0, "R5 trigger beats tick", cnt_o, 0);

    wr(0, 2); wr(1, 1); rd(); wr(2, 4);
    ticks(1);
    chk(cnt_o == 0 && stat_o[0] == 1, "R2 delta one", cnt_o, 0);

    wr(0, 0); wr(1, 100); rd(); wr(2, 4);
    ticks(100);
    chk(cnt_o == 100 && stat_o[0] == 1, "R3 pass compare no restart", cnt_o, 100);
    chk(stat_o[1] == 0, "R11 mode write took effect", stat_o, 1);
    rd();
    ticks(65435);
    chk(cnt_o == 16'hFFFF && stat_o == 0, "R3 top of range", cnt_o, 65535);
    ticks(1);
    chk(cnt_o == 0 && stat_o == 2, "R3 wrap overflow flag", stat_o, 2);

    summary();
    $finish;
  end

endmodule